// File: doc/BRIEF.md
# Serial EEPROM Device Emulator

This block stands in for a small three-wire serial memory of 64 words by 16 bits. A host drives a select line, a serial clock and a serial data line, and reads the data-out line. Every command is a 9-bit frame. A leading 1 marks the start. A 2-bit opcode and a 6-bit address follow, and write commands add 16 bits of data. The block reads words out as a stream that steps through the addresses. It programs single words or the whole array, and guards every change with a write-enable latch.

A fast system clock runs all of the logic. The three serial inputs pass through a synchronizer and are edge-detected. When the host drops select after a valid programming command, a counter runs for a fixed number of system clocks and the array is updated when it finishes. While the counter runs, raising select shows the busy state on data-out.

Top module: `serial_eeprom_emu`

## Requirements
- R1: A frame begins with a 1 sampled on a serial clock rise while select is high. Leading 0s are skipped. Next come opcode bits (MSB first) and six address bits (MSB first). Opcode 10 reads, 01 writes and 11 erases one word. Opcode 00 decodes the two top address bits: 11 enables writes, 00 disables writes, 01 writes all words and 10 erases all words. The four low address bits are then ignored.
- R2: After the last address bit of a read, data-out shows one 0. Each following serial clock rise then presents the next bit of the word, MSB first. Data-out changes only after serial clock rises.
- R3: While select stays high after the 16th bit of a word, the read continues with the word at the next address. Address 63 is followed by address 0.
- R4: The write-enable latch is clear after reset. Write, erase, write-all and erase-all change nothing while it is clear. Enable and disable commands do not affect reads.
- R5: Programming starts when select falls. Only the last 16 data bits shifted in are stored. A write with fewer than 16 data bits programs nothing.
- R6: Erase sets one word to 16'hFFFF. Erase-all sets every word to 16'hFFFF. Write-all stores its 16-bit pattern in every word.
- R7: After programming starts, data-out with select high reads 0 for PROG_CYCLES system clocks and reads 1 after that.
- R8: A serial clock rise with select high and data-in high clears the ready/busy display, and data-out then reads 0.
- R9: Frames sent while programming is in progress are ignored and change no word.
- R10: While select is low, data-out is 0 and any partly received frame is discarded.
- R11: After reset every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock from host |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out, 0 when idle |

## Verification
A wrong write-enable latch or a wrong programming target stays hidden until a later read returns a word that differs from what the frame history implies. A wrong bit counter or address register shows up within one serial clock as a misplaced dummy bit, or as a word that shifts in the middle of a stream. A busy counter that stops early or late shows at the ports as soon as select is raised, because data-out flips to 1 at the wrong time.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {S_WAIT, S_CMD, S_READ, S_DATA, S_ARMED, S_SKIP} ser_state_e;
  typedef enum logic [1:0] {PK_NONE, PK_ONE, PK_ALL} prog_kind_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERAL  = 2'b10;
  localparam logic [1:0] SUB_WEN   = 2'b11;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign rise_o[g] = chain[STAGES-1] & ~prev;
    assign fall_o[g] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we_all | (we_one & (waddr == ADDR_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '1;
      else if (hit) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  p_we_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_one && we_all));
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              we_one,
  output logic              we_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              dout
);
  localparam int CMD_W = 2 + ADDR_W;
  localparam int CMAX  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] take_bit(input logic [DATA_W-1:0] w, input logic b);
    return {w[DATA_W-2:0], b};
  endfunction

  function automatic logic prog_armed(input ser_state_e st, input logic [CNT_W-1:0] n);
    return (st == S_ARMED) || (st == S_DATA && n == CNT_W'(DATA_W));
  endfunction

  ser_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q, pa_q;
  logic [DATA_W-1:0] sh_q, pd_q;
  prog_kind_e        pk_q;
  logic              load_q, dout_q, wen_q, busy_q, flag_q;
  logic [TMR_W-1:0]  timer_q;

  // named events
  logic [CMD_W-1:0]  cmd_word;
  logic [1:0]        opc, sub;
  logic [ADDR_W-1:0] cmd_addr;
  logic              start_bit, cmd_last, prog_start, prog_done, flag_clear;

  assign cmd_word   = {cmd_q[CMD_W-2:0], din};
  assign opc        = cmd_word[CMD_W-1 -: 2];
  assign cmd_addr   = cmd_word[ADDR_W-1:0];
  assign sub        = cmd_word[ADDR_W-1 -: 2];
  assign start_bit  = cs_lvl && sck_rise && din && state_q == S_WAIT && !busy_q;
  assign cmd_last   = cs_lvl && sck_rise && state_q == S_CMD && cnt_q == CNT_W'(CMD_W-1);
  assign prog_start = cs_fall && prog_armed(state_q, cnt_q) && wen_q && !busy_q;
  assign prog_done  = busy_q && timer_q == TMR_W'(1);
  assign flag_clear = cs_lvl && sck_rise && din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_WAIT;
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      sh_q    <= '0;
      pd_q    <= '0;
      pk_q    <= PK_NONE;
      load_q  <= 1'b0;
      dout_q  <= 1'b0;
      wen_q   <= 1'b0;
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      // programming timer (R7)
      if (prog_start) begin
        busy_q  <= 1'b1;
        timer_q <= TMR_W'(PROG_CYCLES);
        flag_q  <= 1'b1;
      end else if (busy_q) begin
        timer_q <= timer_q - TMR_W'(1);
        if (prog_done) busy_q <= 1'b0;
      end
      if (flag_clear) flag_q <= 1'b0;  // R8

      if (load_q) begin
        sh_q   <= rd_word;
        load_q <= 1'b0;
      end

      if (!cs_lvl) begin
        state_q <= S_WAIT;              // R10
      end else if (sck_rise) begin
        case (state_q)
          S_WAIT: if (start_bit) begin
            state_q <= S_CMD;
            cnt_q   <= '0;
          end
          S_CMD: begin
            cmd_q <= cmd_word;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cmd_last) begin
              cnt_q <= '0;
              case (opc)                // R1 decode
                OPC_READ: begin
                  state_q <= S_READ;
                  addr_q  <= cmd_addr;
                  load_q  <= 1'b1;
                  dout_q  <= 1'b0;
                end
                OPC_WRITE: begin
                  state_q <= S_DATA;
                  pa_q    <= cmd_addr;
                  pk_q    <= PK_ONE;
                end
                OPC_ERASE: begin
                  state_q <= S_ARMED;
                  pa_q    <= cmd_addr;
                  pd_q    <= '1;
                  pk_q    <= PK_ONE;
                end
                default: begin
                  case (sub)
                    SUB_WEN:   begin wen_q <= 1'b1; state_q <= S_SKIP; end
                    SUB_WDS:   begin wen_q <= 1'b0; state_q <= S_SKIP; end
                    SUB_WRALL: begin state_q <= S_DATA;  pk_q <= PK_ALL; end
                    default:   begin state_q <= S_ARMED; pk_q <= PK_ALL; pd_q <= '1; end
                  endcase
                end
              endcase
            end
          end
          S_READ: begin
            dout_q <= sh_q[DATA_W-1];   // R2
            if (cnt_q == CNT_W'(DATA_W-1)) begin
              cnt_q  <= '0;
              addr_q <= addr_step(addr_q);  // R3
              load_q <= 1'b1;
            end else begin
              sh_q  <= sh_q << 1;
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_DATA: begin
            pd_q <= take_bit(pd_q, din);    // R5 keeps last bits
            if (cnt_q != CNT_W'(DATA_W)) cnt_q <= cnt_q + CNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = addr_q;
  assign wr_addr = pa_q;
  assign wr_data = pd_q;
  assign we_one  = prog_done && pk_q == PK_ONE;
  assign we_all  = prog_done && pk_q == PK_ALL;
  assign busy    = busy_q;
  assign dout    = cs_lvl && ((state_q == S_READ) ? dout_q : (flag_q && !busy_q));

  p_start_needs_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wen_q));
  p_target_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(pa_q) && $stable(pd_q) && $stable(pk_q)));
  p_dout_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(dout_q));
  p_idle_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |=> state_q == S_WAIT);
  p_busy_ends_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(we_one || we_all));
endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic din_i,
  output logic dout_o
);
  logic [2:0]        lvl, rise, fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_word, wr_data;
  logic              we_one, we_all, busy;

  eep_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) i_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({cs_i, sck_i, din_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(lvl[2]), .cs_fall(fall[2]), .sck_rise(rise[1]), .din(lvl[0]),
    .rd_word(rd_word), .rd_addr(rd_addr),
    .we_one(we_one), .we_all(we_all), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .dout(dout_o)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
    .waddr(wr_addr), .wdata(wr_data), .raddr(rd_addr), .rdata(rd_word)
  );

  p_quiet_when_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl[2] |-> !dout_o);
endmodule

// File: tb/test_serial_eeprom_emu.sv
module test_serial_eeprom_emu;
  localparam int PROG = 300;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_eeprom_emu #(.PROG_CYCLES(PROG)) i_serial_eeprom_emu (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .din_i(din), .dout_o(dout)
  );

  localparam logic [21:0] VEC [6] = '{
    {6'd0,  16'h8001}, {6'd63, 16'h7FFE}, {6'd21, 16'hA5A5},
    {6'd42, 16'h5A5A}, {6'd1,  16'h0000}, {6'd62, 16'h1357}
  };

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    din = b; wclk(4); sck = 1'b1; wclk(4); sck = 1'b0; wclk(1);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_up;   cs = 1'b1; wclk(4); endtask
  task automatic cs_down; cs = 1'b0; din = 1'b0; wclk(6); endtask

  task automatic instr(input logic [1:0] opc, input logic [5:0] a, input logic [31:0] d, input int nd);
    cs_up;
    send_bits({23'd0, 1'b1, opc, a}, 9);
    if (nd > 0) send_bits(d, nd);
    cs_down;
  endtask

  task automatic wait_ready(output int clks);
    clks = 0;
    while (dout !== 1'b1 && clks < 2000) begin wclk(1); clks++; end
  endtask

  task automatic read_words(input logic [5:0] a, input int n, output logic dum,
                            output logic [15:0] w0, output logic [15:0] w1);
    w0 = 'x; w1 = 'x;
    cs_up;
    send_bits({23'd0, 1'b1, 2'b10, a}, 9);
    dum = dout;
    for (int k = 0; k < n; k++)
      for (int b = 15; b >= 0; b--) begin
        bit_out(1'b0);
        if (k == 0) w0[b] = dout; else w1[b] = dout;
      end
    cs_down;
  endtask

  // program and wait; returns busy sample seen right after select rises
  task automatic prog_and_wait(input logic [1:0] opc, input logic [5:0] a,
                               input logic [31:0] d, input int nd, output logic busy_seen, output int clks);
    instr(opc, a, d, nd);
    cs_up;
    busy_seen = dout;
    wait_ready(clks);
    cs_down;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic dum, bs;
    logic [15:0] w0, w1;
    int clks;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);

    // R10 idle output, R11 reset contents, R2 dummy bit
    check(dout === 1'b0, "R10 idle dout", 32'(dout), 0);
    read_words(6'd5, 1, dum, w0, w1);
    check(dum === 1'b0, "R2 dummy bit", 32'(dum), 0);
    check(w0 === 16'hFFFF, "R11 reset word", 32'(w0), 32'hFFFF);

    // R4 protected write with latch clear
    instr(2'b01, 6'd5, 32'h1234, 16);
    cs_up;
    check(dout === 1'b0, "R4 no busy flag when protected", 32'(dout), 0);
    cs_down;
    read_words(6'd5, 1, dum, w0, w1);
    check(w0 === 16'hFFFF, "R4 protected write", 32'(w0), 32'hFFFF);

    // R1 enable with don't-care low bits
    instr(2'b00, 6'b11_1010, 0, 0);

    // vector table: write then read back (R5, R7, R2)
    foreach (VEC[i]) begin
      prog_and_wait(2'b01, VEC[i][21:16], {16'd0, VEC[i][15:0]}, 16, bs, clks);
      check(bs === 1'b0, "R7 busy shown", 32'(bs), 0);
      check(clks >= PROG - 20 && clks <= PROG + 10, "R7 busy length", 32'(clks), PROG);
    end
    foreach (VEC[i]) begin
      read_words(VEC[i][21:16], 1, dum, w0, w1);
      check(w0 === VEC[i][15:0] && dum === 1'b0, "R5 table readback", 32'(w0), 32'(VEC[i][15:0]));
    end

    // R8: ready flag cleared by clock with din high
    instr(2'b01, 6'd10, 32'h0BAD, 16);
    cs_up;
    wait_ready(clks);
    check(dout === 1'b1, "R7 ready shown", 32'(dout), 1);
    bit_out(1'b1);
    check(dout === 1'b0, "R8 flag cleared", 32'(dout), 0);
    cs_down;

    // R3 wrap from 63 to 0
    read_words(6'd63, 2, dum, w0, w1);
    check(w0 === 16'h7FFE, "R3 first word", 32'(w0), 32'h7FFE);
    check(w1 === 16'h8001, "R3 wrapped word", 32'(w1), 32'h8001);

    // R5 over-long data keeps last 16
    prog_and_wait(2'b01, 6'd7, 32'h000ABCDE, 20, bs, clks);
    read_words(6'd7, 1, dum, w0, w1);
    check(w0 === 16'hBCDE, "R5 last sixteen", 32'(w0), 32'hBCDE);

    // R5 short data programs nothing
    instr(2'b01, 6'd7, 32'h123, 12);
    cs_up;
    check(dout === 1'b0, "R5 short no program", 32'(dout), 0);
    cs_down;
    read_words(6'd7, 1, dum, w0, w1);
    check(w0 === 16'hBCDE, "R5 short unchanged", 32'(w0), 32'hBCDE);

    // R6 erase one word
    prog_and_wait(2'b11, 6'd7, 0, 0, bs, clks);
    read_words(6'd7, 1, dum, w0, w1);
    check(w0 === 16'hFFFF, "R6 erase word", 32'(w0), 32'hFFFF);

    // R9 frame during busy ignored
    instr(2'b01, 6'd8, 32'h5555, 16);
    instr(2'b01, 6'd9, 32'h0F0F, 16);
    cs_up; wait_ready(clks); cs_down;
    read_words(6'd8, 2, dum, w0, w1);
    check(w0 === 16'h5555, "R9 first write kept", 32'(w0), 32'h5555);
    check(w1 === 16'hFFFF, "R9 busy frame ignored", 32'(w1), 32'hFFFF);

    // R4 disable blocks writes, reads still work
    instr(2'b00, 6'b00_0101, 0, 0);
    instr(2'b01, 6'd8, 32'h0000, 16);
    read_words(6'd8, 1, dum, w0, w1);
    check(w0 === 16'h5555, "R4 disabled write", 32'(w0), 32'h5555);

    // R10 partial frame discarded
    cs_up; send_bits(32'b101, 3); cs_down;
    read_words(6'd21, 1, dum, w0, w1);
    check(w0 === 16'hA5A5, "R10 after partial", 32'(w0), 32'hA5A5);

    // R6 erase-all then write-all
    instr(2'b00, 6'b11_0000, 0, 0);
    prog_and_wait(2'b00, 6'b10_0110, 0, 0, bs, clks);
    read_words(6'd42, 2, dum, w0, w1);
    check(w0 === 16'hFFFF && w1 === 16'hFFFF, "R6 erase all", {w0, w1}, 32'hFFFFFFFF);
    prog_and_wait(2'b00, 6'b01_1111, 32'hC3A5, 16, bs, clks);
    read_words(6'd62, 2, dum, w0, w1);
    check(w0 === 16'hC3A5 && w1 === 16'hC3A5, "R6 write all", {w0, w1}, 32'hC3A5C3A5);
    read_words(6'd0, 1, dum, w0, w1);
    check(w0 === 16'hC3A5, "R6 write all word0", 32'(w0), 32'hC3A5);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule